// File: doc/BRIEF.md
# I2C SCL divider calculator

This block converts a pair of rates into the two count fields that an I2C clock generator needs. The caller supplies the frequency of the generator's input clock and the SCL frequency it wants, both in hertz. The block picks standard-mode or fast-mode bus timing from the requested rate and finds the smallest total period count that keeps SCL at or below the request. That total is then split between the low and high phases. The split respects the minimum low and high times, and it keeps the low phase short enough that data launched at its midpoint still meets the bus hold limit.

All arithmetic runs through one shared shift-and-subtract divider, so a calculation takes a few hundred cycles. The caller pulses `start` while `busy` is low and the inputs are captured at that moment. `done` then pulses once, and the two fields and the error flag stay where they are until the next calculation finishes. The generator adds one to each field it is given, so the results are counts minus one. A count that does not fit the field width saturates and raises `err`.

Top module: `scl_div_calc`

## Requirements
- R1: A requested SCL rate above 400000 Hz is treated as 400000 Hz, and one below 1000 Hz is treated as 1000 Hz. Neither substitution sets `err` on its own.
- R2: When the (substituted) SCL rate is at most 100000 Hz, the limits are low ≥ 4700 ns, high ≥ 4000 ns, data hold ≤ 3450 ns and a 50 ns margin. Above 100000 Hz they are 1300 ns, 600 ns, 900 ns and 50 ns. The longest permitted low time is twice the hold limit minus the margin.
- R3: The clock rate is converted to kHz rounding up, and the SCL rate to kHz rounding down. The minimum total count is ceil(clk_khz / (8·scl_khz)).
- R4: The minimum low count is ceil(clk_khz·low_min_ns / 8000000), and the minimum high count is formed the same way from high_min_ns. The maximum low count is floor(clk_khz·low_max_ns / 8000000). When it is below the minimum low count, it is raised to that count.
- R5: When minimum low plus minimum high exceeds the minimum total, the low and high counts are the two minimums.
- R6: Otherwise spare = total − (min low + min high). The low count is ceil(clk_khz·low_min_ns / (8·scl_khz·(low_min_ns+high_min_ns))), capped first at the maximum low count and then at min low + spare. The high count is min high plus whatever spare the low count did not take.
- R7: `div_low` and `div_high` carry each count minus one. A count of zero, or a count minus one above 65535, gives 0xFFFF in that field and sets `err`. Otherwise `err` is 0.
- R8: `start` is accepted only while `busy` is low, and `busy` is high in the following cycle. The rates are captured at acceptance. `start` and input changes while `busy` is high have no effect.
- R9: `done` is high for exactly one cycle per accepted `start`, with `busy` low. The outputs change only in that cycle and hold until the next `done`.
- R10: After reset, `busy`, `done` and `err` are 0 and both divider fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken when busy is low) |
| clk_rate_hz | input | 32 | Generator input clock frequency in Hz |
| scl_rate_hz | input | 32 | Requested SCL frequency in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| div_low | output | 16 | Low-phase count minus one |
| div_high | output | 16 | High-phase count minus one |
| err | output | 1 | Request could not be met within the field width |

## Verification
The sweep crosses clock rates from 1 kHz to the 32-bit maximum with SCL requests on both sides of each clamp and of the 100 kHz mode boundary. A mode compare written with the wrong inequality, or a clamp that raises `err`, shows up at exactly 100000 Hz, 100001 Hz and the out-of-range requests. Low clock rates drive the hold-dominated path, where a missing raise of the maximum low count or an inverted path choice gives wrong counts. High clock rates with slow SCL overflow the fields, and there a design without saturation would return wrapped values with `err` low. A zero clock rate must report saturation rather than wrap to a small count. Directed runs also fire `start` and change the inputs mid-calculation, which would corrupt the result of a design that re-samples or restarts.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // Nanosecond limits for the slower bus timing class
    localparam logic [15:0] STD_LOW_MIN_NS  = 16'd4700;
    localparam logic [15:0] STD_HIGH_MIN_NS = 16'd4000;
    localparam logic [15:0] STD_HOLD_MAX_NS = 16'd3450;
    // Nanosecond limits for the faster bus timing class
    localparam logic [15:0] FST_LOW_MIN_NS  = 16'd1300;
    localparam logic [15:0] FST_HIGH_MIN_NS = 16'd600;
    localparam logic [15:0] FST_HOLD_MAX_NS = 16'd900;
    // Margin taken off the doubled hold limit
    localparam logic [15:0] HOLD_MARGIN_NS  = 16'd50;

    typedef struct packed {
        logic [15:0] low_min_ns;
        logic [15:0] high_min_ns;
        logic [15:0] low_max_ns;
        logic [15:0] period_min_ns;
    } limits_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_KHZ,
        ST_SCL_KHZ,
        ST_TOTAL,
        ST_LOW_MIN,
        ST_HIGH_MIN,
        ST_LOW_MAX,
        ST_LOW_IDEAL,
        ST_FINISH
    } calc_state_e;

endpackage

// File: rtl/scl_div_limits.sv
module scl_div_limits
    import scl_div_pkg::*;
(
    input  logic    fast_mode,
    output limits_t lim
);
    logic [15:0] hold_ns;

    always_comb begin
        if (fast_mode) begin
            lim.low_min_ns  = FST_LOW_MIN_NS;
            lim.high_min_ns = FST_HIGH_MIN_NS;
            hold_ns         = FST_HOLD_MAX_NS;
        end else begin
            lim.low_min_ns  = STD_LOW_MIN_NS;
            lim.high_min_ns = STD_HIGH_MIN_NS;
            hold_ns         = STD_HOLD_MAX_NS;
        end
        // data changes mid-low, so low may span twice the hold window
        lim.low_max_ns    = (hold_ns << 1) - HOLD_MARGIN_NS;
        lim.period_min_ns = lim.low_min_ns + lim.high_min_ns;
    end
endmodule

// File: rtl/scl_div_seqdiv.sv
module scl_div_seqdiv #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic         rem_nz
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic         active;
        logic [CW-1:0] cnt;
        logic [W:0]   rem;
        logic [W-1:0] quo;
        logic [W-1:0] den;
        logic         fin;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       take;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        shifted = {s_q.rem[W-1:0], s_q.quo[W-1]};
        trial   = shifted - {1'b0, s_q.den};
        take    = (shifted >= {1'b0, s_q.den});
        if (s_q.active) begin
            s_d.rem = take ? trial : shifted;
            s_d.quo = {s_q.quo[W-2:0], take};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.active = 1'b0;
                s_d.fin    = 1'b1;
            end
        end else if (go) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.rem    = '0;
            s_d.quo    = num;
            s_d.den    = den;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fin    = s_q.fin;
    assign quo    = s_q.quo;
    assign rem_nz = |s_q.rem;
endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
    import scl_div_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int OUT_W  = 16,
    parameter int CALC_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] clk_rate_hz,
    input  logic [RATE_W-1:0] scl_rate_hz,
    output logic              busy,
    output logic              done,
    output logic [OUT_W-1:0]  div_low,
    output logic [OUT_W-1:0]  div_high,
    output logic              err
);
    localparam logic [RATE_W-1:0] SCL_CEIL_HZ  = RATE_W'(400000);
    localparam logic [RATE_W-1:0] SCL_FLOOR_HZ = RATE_W'(1000);
    localparam logic [RATE_W-1:0] SLOW_MAX_HZ  = RATE_W'(100000);
    localparam logic [CALC_W-1:0] HZ_PER_KHZ   = CALC_W'(1000);
    localparam logic [CALC_W-1:0] NS_SCALE     = CALC_W'(8000000);
    localparam logic [CALC_W-1:0] FIELD_MAX    = CALC_W'({OUT_W{1'b1}});

    typedef struct packed {
        calc_state_e       st;
        logic              launched;
        logic [RATE_W-1:0] clk_hz;
        logic [RATE_W-1:0] scl_hz;
        logic [CALC_W-1:0] clk_khz;
        logic [CALC_W-1:0] scl_khz;
        logic [CALC_W-1:0] total;
        logic [CALC_W-1:0] low_min;
        logic [CALC_W-1:0] high_min;
        logic [CALC_W-1:0] low_max;
        logic [CALC_W-1:0] low_ideal;
        logic [OUT_W-1:0]  lo;
        logic [OUT_W-1:0]  hi;
        logic              err;
        logic              done;
    } calc_regs_t;

    calc_regs_t r_d, r_q;

    limits_t           lim;
    logic              fast_mode;
    logic              div_go;
    logic [CALC_W-1:0] div_num;
    logic [CALC_W-1:0] div_den;
    logic              div_fin;
    logic [CALC_W-1:0] div_quo;
    logic              div_rem_nz;
    logic [CALC_W-1:0] div_ceil;

    logic [CALC_W-1:0] low_min_ns_w;
    logic [CALC_W-1:0] high_min_ns_w;
    logic [CALC_W-1:0] low_max_ns_w;
    logic [CALC_W-1:0] period_ns_w;

    logic [CALC_W-1:0] eff_low_max;
    logic [CALC_W-1:0] hold_sum;
    logic [CALC_W-1:0] spare;
    logic [CALC_W-1:0] low_pick;
    logic [CALC_W-1:0] low_cnt;
    logic [CALC_W-1:0] high_cnt;
    logic [OUT_W:0]    low_field;
    logic [OUT_W:0]    high_field;

    function automatic logic [OUT_W:0] to_field(input logic [CALC_W-1:0] cnt);
        logic [CALC_W-1:0] less_one;
        less_one = cnt - 1'b1;
        if (cnt == '0 || less_one > FIELD_MAX) to_field = {1'b1, {OUT_W{1'b1}}};
        else                                   to_field = {1'b0, less_one[OUT_W-1:0]};
    endfunction

    assign fast_mode = (r_q.scl_hz > SLOW_MAX_HZ);

    scl_div_limits u_limits (
        .fast_mode (fast_mode),
        .lim       (lim)
    );

    scl_div_seqdiv #(.W(CALC_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (div_go),
        .num    (div_num),
        .den    (div_den),
        .fin    (div_fin),
        .quo    (div_quo),
        .rem_nz (div_rem_nz)
    );

    assign low_min_ns_w  = CALC_W'(lim.low_min_ns);
    assign high_min_ns_w = CALC_W'(lim.high_min_ns);
    assign low_max_ns_w  = CALC_W'(lim.low_max_ns);
    assign period_ns_w   = CALC_W'(lim.period_min_ns);
    assign div_ceil      = div_quo + CALC_W'(div_rem_nz);

    // operand selection for the shared divider
    always_comb begin
        div_num = '0;
        div_den = HZ_PER_KHZ;
        unique case (r_q.st)
            ST_CLK_KHZ: begin
                div_num = CALC_W'(r_q.clk_hz);
                div_den = HZ_PER_KHZ;
            end
            ST_SCL_KHZ: begin
                div_num = CALC_W'(r_q.scl_hz);
                div_den = HZ_PER_KHZ;
            end
            ST_TOTAL: begin
                div_num = r_q.clk_khz;
                div_den = r_q.scl_khz << 3;
            end
            ST_LOW_MIN: begin
                div_num = r_q.clk_khz * low_min_ns_w;
                div_den = NS_SCALE;
            end
            ST_HIGH_MIN: begin
                div_num = r_q.clk_khz * high_min_ns_w;
                div_den = NS_SCALE;
            end
            ST_LOW_MAX: begin
                div_num = r_q.clk_khz * low_max_ns_w;
                div_den = NS_SCALE;
            end
            ST_LOW_IDEAL: begin
                div_num = r_q.clk_khz * low_min_ns_w;
                div_den = (r_q.scl_khz << 3) * period_ns_w;
            end
            default: begin
                div_num = '0;
                div_den = HZ_PER_KHZ;
            end
        endcase
    end

    // split of the total between low and high phases
    always_comb begin
        eff_low_max = (r_q.low_min > r_q.low_max) ? r_q.low_min : r_q.low_max;
        hold_sum    = r_q.low_min + r_q.high_min;
        spare       = '0;
        low_pick    = r_q.low_ideal;
        if (hold_sum > r_q.total) begin
            low_cnt  = r_q.low_min;
            high_cnt = r_q.high_min;
        end else begin
            spare = r_q.total - hold_sum;
            if (low_pick > eff_low_max)           low_pick = eff_low_max;
            if (low_pick > r_q.low_min + spare)   low_pick = r_q.low_min + spare;
            low_cnt  = low_pick;
            high_cnt = r_q.high_min + (spare - (low_pick - r_q.low_min));
        end
        low_field  = to_field(low_cnt);
        high_field = to_field(high_cnt);
    end

    // sequencing
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.clk_hz = clk_rate_hz;
                    if (scl_rate_hz > SCL_CEIL_HZ)       r_d.scl_hz = SCL_CEIL_HZ;
                    else if (scl_rate_hz < SCL_FLOOR_HZ) r_d.scl_hz = SCL_FLOOR_HZ;
                    else                                 r_d.scl_hz = scl_rate_hz;
                    r_d.launched = 1'b0;
                    r_d.st       = ST_CLK_KHZ;
                end
            end
            ST_FINISH: begin
                r_d.lo   = low_field[OUT_W-1:0];
                r_d.hi   = high_field[OUT_W-1:0];
                r_d.err  = low_field[OUT_W] | high_field[OUT_W];
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                if (!r_q.launched) begin
                    div_go       = 1'b1;
                    r_d.launched = 1'b1;
                end else if (div_fin) begin
                    r_d.launched = 1'b0;
                    unique case (r_q.st)
                        ST_CLK_KHZ: begin
                            r_d.clk_khz = div_ceil;
                            r_d.st      = ST_SCL_KHZ;
                        end
                        ST_SCL_KHZ: begin
                            r_d.scl_khz = div_quo;
                            r_d.st      = ST_TOTAL;
                        end
                        ST_TOTAL: begin
                            r_d.total = div_ceil;
                            r_d.st    = ST_LOW_MIN;
                        end
                        ST_LOW_MIN: begin
                            r_d.low_min = div_ceil;
                            r_d.st      = ST_HIGH_MIN;
                        end
                        ST_HIGH_MIN: begin
                            r_d.high_min = div_ceil;
                            r_d.st       = ST_LOW_MAX;
                        end
                        ST_LOW_MAX: begin
                            r_d.low_max = div_quo;
                            r_d.st      = ST_LOW_IDEAL;
                        end
                        default: begin
                            r_d.low_ideal = div_ceil;
                            r_d.st        = ST_FINISH;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign div_low  = r_q.lo;
    assign div_high = r_q.hi;
    assign err      = r_q.err;
endmodule

// File: rtl/scl_div_calc_chk.sv
module scl_div_calc_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] div_low,
    input logic [OUT_W-1:0] div_high,
    input logic             err
);
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(div_low) && $stable(div_high) && $stable(err)));

    a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_err_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (div_low == {OUT_W{1'b1}} || div_high == {OUT_W{1'b1}}));
endmodule

bind scl_div_calc scl_div_calc_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_low  (div_low),
    .div_high (div_high),
    .err      (err)
);

// File: tb/scl_div_calc_tb.sv
module scl_div_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] clk_in = '0;
    logic [31:0] scl_in = '0;
    logic        busy, done, err;
    logic [15:0] div_low, div_high;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    scl_div_calc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .clk_rate_hz (clk_in),
        .scl_rate_hz (scl_in),
        .busy        (busy),
        .done        (done),
        .div_low     (div_low),
        .div_high    (div_high),
        .err         (err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned cdiv(input longint unsigned a, input longint unsigned b);
        return (a + b - 1) / b;
    endfunction

    // expected results from the requirement formulas
    task automatic model(input longint unsigned c, input longint unsigned s,
                         output logic [15:0] lo, output logic [15:0] hi,
                         output logic e, output bit hold_path);
        longint unsigned lmin_ns, hmin_ns, hold_ns, lmax_ns, ck, sk;
        longint unsigned tot, lmin, hmin, lmax, sum, spare, ideal, lcnt, hcnt;
        if (s > 400000) s = 400000;
        if (s < 1000)   s = 1000;
        if (s <= 100000) begin lmin_ns = 4700; hmin_ns = 4000; hold_ns = 3450; end
        else             begin lmin_ns = 1300; hmin_ns = 600;  hold_ns = 900;  end
        lmax_ns = hold_ns * 2 - 50;
        ck   = cdiv(c, 1000);
        sk   = s / 1000;
        tot  = cdiv(ck, sk * 8);
        lmin = cdiv(ck * lmin_ns, 8000000);
        hmin = cdiv(ck * hmin_ns, 8000000);
        lmax = (ck * lmax_ns) / 8000000;
        if (lmin > lmax) lmax = lmin;
        sum = lmin + hmin;
        hold_path = (sum > tot);
        if (hold_path) begin
            lcnt = lmin; hcnt = hmin;
        end else begin
            spare = tot - sum;
            ideal = cdiv(ck * lmin_ns, sk * 8 * (lmin_ns + hmin_ns));
            if (ideal > lmax) ideal = lmax;
            if (ideal > lmin + spare) ideal = lmin + spare;
            lcnt = ideal;
            hcnt = hmin + (spare - (ideal - lmin));
        end
        e = 1'b0;
        if (lcnt == 0 || lcnt - 1 > 65535) begin lo = 16'hFFFF; e = 1'b1; end
        else lo = 16'(lcnt - 1);
        if (hcnt == 0 || hcnt - 1 > 65535) begin hi = 16'hFFFF; e = 1'b1; end
        else hi = 16'(hcnt - 1);
    endtask

    // one calculation; disturb fires start and new inputs mid-run
    task automatic run(input logic [31:0] c, input logic [31:0] s, input bit disturb,
                       output logic [15:0] lo, output logic [15:0] hi, output logic e);
        int waited;
        @(negedge clk);
        waited = 0;
        while (busy && waited < 5000) begin @(negedge clk); waited++; end
        clk_in = c; scl_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R8", "busy after start", longint'(busy), 1);
        waited = 0;
        while (done !== 1'b1 && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (disturb && waited == 7) begin
                start = 1'b1; clk_in = ~c; scl_in = s ^ 32'h5A5A5;
            end else if (disturb && waited == 8) begin
                start = 1'b0;
            end
        end
        check(waited < 5000, "R9", "watchdog waiting for done", waited, 0);
        check(busy === 1'b0, "R9", "busy low with done", longint'(busy), 0);
        lo = div_low; hi = div_high; e = err;
        @(negedge clk);
        check(done === 1'b0, "R9", "done one cycle", longint'(done), 0);
    endtask

    task automatic sweep_one(input logic [31:0] c, input logic [31:0] s);
        logic [15:0] lo, hi, elo, ehi;
        logic e, ee;
        bit hp;
        string tag;
        model(c, s, elo, ehi, ee, hp);
        run(c, s, 1'b0, lo, hi, e);
        tag = hp ? "R2 R3 R4 R5 R7" : "R2 R3 R4 R6 R7";
        check(lo === elo, tag, $sformatf("div_low clk=%0d scl=%0d", c, s), lo, elo);
        check(hi === ehi, tag, $sformatf("div_high clk=%0d scl=%0d", c, s), hi, ehi);
        check(e === ee, tag, $sformatf("err clk=%0d scl=%0d", c, s), e, ee);
    endtask

    logic [31:0] clk_list [12] = '{32'd1000, 32'd999999, 32'd12000000, 32'd24000000,
                                   32'd50000000, 32'd66666667, 32'd100000000, 32'd133000000,
                                   32'd200000000, 32'd400000000, 32'd1000000000, 32'hFFFFFFFF};
    logic [31:0] scl_list [14] = '{32'd0, 32'd500, 32'd999, 32'd1000, 32'd1999, 32'd50000,
                                   32'd99999, 32'd100000, 32'd100001, 32'd100999, 32'd250000,
                                   32'd399999, 32'd400000, 32'd1000000};

    initial begin
        logic [15:0] lo_a, hi_a, lo_b, hi_b, elo, ehi;
        logic e_a, e_b, ee;
        bit hp;

        // R10: reset values
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R10", "busy in reset", busy, 0);
        check(done === 1'b0, "R10", "done in reset", done, 0);
        check(err === 1'b0, "R10", "err in reset", err, 0);
        check(div_low === 16'd0, "R10", "div_low in reset", div_low, 0);
        check(div_high === 16'd0, "R10", "div_high in reset", div_high, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && div_low === 16'd0, "R10", "idle after reset", busy, 0);

        foreach (clk_list[i]) foreach (scl_list[j]) sweep_one(clk_list[i], scl_list[j]);

        // R7: zero clock rate saturates both fields
        sweep_one(32'd0, 32'd100000);

        // R1: out-of-range requests match the clamp values, no error
        run(32'd100000000, 32'd5000000, 1'b0, lo_a, hi_a, e_a);
        run(32'd100000000, 32'd400000, 1'b0, lo_b, hi_b, e_b);
        check(lo_a === lo_b && hi_a === hi_b, "R1", "upper clamp low", lo_a, lo_b);
        check(e_a === 1'b0, "R1", "upper clamp err", e_a, 0);
        run(32'd8000000, 32'd1, 1'b0, lo_a, hi_a, e_a);
        run(32'd8000000, 32'd1000, 1'b0, lo_b, hi_b, e_b);
        check(lo_a === lo_b && hi_a === hi_b, "R1", "lower clamp high", hi_a, hi_b);
        check(e_a === 1'b0, "R1", "lower clamp err", e_a, 0);

        // R8: start and input changes while busy are ignored
        model(32'd48000000, 32'd400000, elo, ehi, ee, hp);
        run(32'd48000000, 32'd400000, 1'b1, lo_a, hi_a, e_a);
        check(lo_a === elo, "R8", "div_low with mid-run start", lo_a, elo);
        check(hi_a === ehi, "R8", "div_high with mid-run start", hi_a, ehi);
        repeat (5) @(negedge clk);
        check(busy === 1'b0, "R8", "no second run from ignored start", busy, 0);

        // R9: outputs hold with inputs moving and no start
        clk_in = 32'd7; scl_in = 32'd123456;
        repeat (20) @(negedge clk);
        check(div_low === lo_a, "R9", "div_low holds", div_low, lo_a);
        check(div_high === hi_a, "R9", "div_high holds", div_high, hi_a);
        check(done === 1'b0, "R9", "no spurious done", done, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule